// File: doc/BRIEF.md
# Ramp ADC conversion controller

This block is the digital half of a single-slope (counting) analog-to-digital converter. It owns a binary counter whose value drives an external DAC. An external comparator reports whether the held analog input is still above the DAC output. On a start request the controller clears the counter and puts the external sample-and-hold into hold. After one settling cycle it counts up one code per clock. It stops when the comparator reports that the DAC has caught up with the input. Conversion time therefore grows with the input value and reaches about 2^WIDTH clocks at full scale.

The comparator flag arrives asynchronously and passes through a flop synchronizer. The synchronized answer describes a code the counter left behind some cycles earlier. The controller therefore carries each code down a short pipeline next to the synchronizer. When the first synchronized trip arrives, the controller reports the exact code that caused it, not the overshot counter. If the counter reaches all-ones and the comparator has still not tripped, the conversion ends at full scale and an over-range flag is raised.

Top module: `ramp_adc_ctrl`

## Requirements
- R1: While reset is held and after it is released with no start, busy_o, hold_o, done_o and over_range_o read 0, and dac_code_o and result_o read 0.
- R2: A start_i sampled high while idle is accepted. In the following cycle busy_o and hold_o read 1 and dac_code_o reads 0.
- R3: The code stays 0 for one settling cycle after acceptance. It then increases by exactly one each clock (0,0,1,2,... in the first four cycles after acceptance) until the conversion ends.
- R4: cmp_above_i is 1 while the input is above the DAC output. It passes through SYNC_STAGES flops. The result is the first code whose synchronized comparison reads 0, which is the smallest code not below the held input. With two stages, done_o is high in the cycle that begins result+4 clocks after the accepting edge.
- R5: done_o is high for exactly one cycle. busy_o and hold_o are 0 in that cycle.
- R6: result_o and over_range_o keep their values from the end of one conversion until the next conversion ends, including during that next conversion.
- R7: start_i is ignored while busy_o is high. The result, the over-range flag and the end time of the running conversion are unchanged.
- R8: If the synchronized comparison of the all-ones code still reads 1, the conversion ends with result all-ones and over_range_o = 1. With two stages this happens 2^WIDTH+3 clocks after acceptance.
- R9: A trip observed on the all-ones code itself ends with result all-ones and over_range_o = 0.
- R10: The code never wraps. Once it reaches all-ones it stays there until the conversion ends.
- R11: A start_i high in the same cycle that done_o is high is accepted, and a new conversion begins at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request, sampled while idle |
| cmp_above_i | input | 1 | Asynchronous comparator: 1 while input is above DAC output |
| dac_code_o | output | WIDTH | Counter value driving the external DAC |
| hold_o | output | 1 | Sample-and-hold command, 1 = hold |
| busy_o | output | 1 | High from acceptance until the end of conversion |
| done_o | output | 1 | One-cycle end-of-conversion strobe |
| result_o | output | WIDTH | Converted code, held until the next completion |
| over_range_o | output | 1 | Set when the input exceeded full scale |

## Verification
Two of the block's decisions can fall into the same cycle. The first pair is a comparator trip and the full-scale ceiling. An input equal to the all-ones code makes the trip arrive exactly when the probed code is all-ones. The bench then expects a full-scale result with the over-range flag clear, and one code higher must give the flag set. The second pair is the done strobe and a fresh start request: the bench raises start in the done cycle and expects a cleared code and busy in the next cycle, while the old result stays visible until the new conversion ends.

// File: rtl/ramp_adc_pkg.sv
package ramp_adc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SAMPLE = 2'd1,
        ST_COUNT  = 2'd2
    } ramp_state_e;

endpackage

// File: rtl/ramp_cmp_sync.sv
module ramp_cmp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = (chain_q << 1) | STAGES'(async_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/ramp_code_pipe.sv
module ramp_code_pipe #(
    parameter int W     = 8,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush_i,
    input  logic         valid_i,
    input  logic [W-1:0] code_i,
    output logic         valid_o,
    output logic [W-1:0] code_o
);

    typedef struct packed {
        logic [DEPTH-1:0]        vld;
        logic [DEPTH-1:0][W-1:0] code;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    always_comb begin
        pipe_d         = pipe_q;
        pipe_d.vld[0]  = valid_i;
        pipe_d.code[0] = code_i;
        for (int i = 1; i < DEPTH; i++) begin
            pipe_d.vld[i]  = pipe_q.vld[i-1];
            pipe_d.code[i] = pipe_q.code[i-1];
        end
        if (flush_i) pipe_d.vld = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign valid_o = pipe_q.vld[DEPTH-1];
    assign code_o  = pipe_q.code[DEPTH-1];

    // R4
    pipe_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(flush_i) |-> !valid_o);

endmodule

// File: rtl/ramp_adc_fsm.sv
module ramp_adc_fsm
    import ramp_adc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         cmp_sync_i,
    input  logic         probe_valid_i,
    input  logic [W-1:0] probe_code_i,
    output logic         count_en_o,
    output logic         flush_o,
    output logic [W-1:0] cnt_o,
    output logic         hold_o,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] result_o,
    output logic         over_o
);

    localparam logic [W-1:0] CODE_MAX = '1;

    typedef struct packed {
        ramp_state_e  state;
        logic [W-1:0] cnt;
        logic [W-1:0] result;
        logic         over;
        logic         done;
        logic         busy;
        logic         hold;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic accept;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        accept     = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    accept      = 1'b1;
                    ctl_d.state = ST_SAMPLE;
                    ctl_d.cnt   = '0;
                    ctl_d.busy  = 1'b1;
                    ctl_d.hold  = 1'b1;
                end
            end
            ST_SAMPLE: begin
                ctl_d.state = ST_COUNT;
            end
            ST_COUNT: begin
                if (probe_valid_i && !cmp_sync_i) begin
                    ctl_d.state  = ST_IDLE;
                    ctl_d.result = probe_code_i;
                    ctl_d.over   = 1'b0;
                    ctl_d.done   = 1'b1;
                    ctl_d.busy   = 1'b0;
                    ctl_d.hold   = 1'b0;
                end else if (probe_valid_i && probe_code_i == CODE_MAX) begin
                    ctl_d.state  = ST_IDLE;
                    ctl_d.result = CODE_MAX;
                    ctl_d.over   = 1'b1;
                    ctl_d.done   = 1'b1;
                    ctl_d.busy   = 1'b0;
                    ctl_d.hold   = 1'b0;
                end else if (ctl_q.cnt != CODE_MAX) begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.state <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign count_en_o = (ctl_q.state == ST_COUNT);
    assign flush_o    = accept || ctl_d.done;
    assign cnt_o      = ctl_q.cnt;
    assign hold_o     = ctl_q.hold;
    assign busy_o     = ctl_q.busy;
    assign done_o     = ctl_q.done;
    assign result_o   = ctl_q.result;
    assign over_o     = ctl_q.over;

    // R2
    sample_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_SAMPLE) |-> (ctl_q.cnt == '0 && ctl_q.hold && ctl_q.busy));

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_COUNT && $past(ctl_q.state) == ST_COUNT && $past(ctl_q.cnt) != CODE_MAX)
        |-> (ctl_q.cnt == $past(ctl_q.cnt) + 1'b1));

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.done |=> !ctl_q.done);

    // R5
    busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl_q.busy) |-> ctl_q.done);

    // R6
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q.done |-> ($stable(ctl_q.result) && $stable(ctl_q.over)));

    // R7
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_COUNT && start_i) |=> (ctl_q.state != ST_SAMPLE));

    // R8
    over_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.over |-> (ctl_q.result == CODE_MAX));

    // R10
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_COUNT && $past(ctl_q.state) == ST_COUNT && $past(ctl_q.cnt) == CODE_MAX)
        |-> (ctl_q.cnt == CODE_MAX));

endmodule

// File: rtl/ramp_adc_ctrl.sv
module ramp_adc_ctrl #(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             cmp_above_i,
    output logic [WIDTH-1:0] dac_code_o,
    output logic             hold_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [WIDTH-1:0] result_o,
    output logic             over_range_o
);

    logic             cmp_sync;
    logic             count_en;
    logic             flush;
    logic             probe_valid;
    logic [WIDTH-1:0] probe_code;
    logic [WIDTH-1:0] cnt;

    ramp_cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (cmp_above_i),
        .sync_o  (cmp_sync)
    );

    ramp_code_pipe #(.W(WIDTH), .DEPTH(SYNC_STAGES)) u_pipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush_i (flush),
        .valid_i (count_en),
        .code_i  (cnt),
        .valid_o (probe_valid),
        .code_o  (probe_code)
    );

    ramp_adc_fsm #(.W(WIDTH)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .cmp_sync_i    (cmp_sync),
        .probe_valid_i (probe_valid),
        .probe_code_i  (probe_code),
        .count_en_o    (count_en),
        .flush_o       (flush),
        .cnt_o         (cnt),
        .hold_o        (hold_o),
        .busy_o        (busy_o),
        .done_o        (done_o),
        .result_o      (result_o),
        .over_o        (over_range_o)
    );

    assign dac_code_o = cnt;

endmodule

// File: tb/tb_ramp_adc_ctrl.sv
`timescale 1ns/1ps
module tb_ramp_adc_ctrl;

    localparam int W    = 8;
    localparam int CMAX = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         start_i;
    logic         cmp_above_i;
    logic [W-1:0] dac_code_o;
    logic         hold_o, busy_o, done_o, over_range_o;
    logic [W-1:0] result_o;

    logic [W:0]   vin_live;
    logic [W:0]   vin_held;
    logic         hold_prev;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    ramp_adc_ctrl #(.WIDTH(W), .SYNC_STAGES(2)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .cmp_above_i  (cmp_above_i),
        .dac_code_o   (dac_code_o),
        .hold_o       (hold_o),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .result_o     (result_o),
        .over_range_o (over_range_o)
    );

    // analog models: sample-and-hold captures on rising hold, comparator is live
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_prev <= 1'b0;
            vin_held  <= '0;
        end else begin
            hold_prev <= hold_o;
            if (hold_o && !hold_prev) vin_held <= vin_live;
        end
    end

    assign cmp_above_i = (vin_held > {1'b0, dac_code_o});

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int expect_code(input int v);
        return (v > CMAX) ? CMAX : v;
    endfunction

    // ends at the negedge of the first cycle after the accepting edge
    task automatic begin_conv(input int v);
        @(negedge clk);
        vin_live = v[W:0];
        start_i  = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i  = 1'b0;
    endtask

    task automatic wait_done(input int first_idx, output int lat);
        int idx = first_idx;
        while (!done_o && idx < 2000) begin
            @(negedge clk);
            idx++;
        end
        lat = idx;
    endtask

    task automatic check_end(input string tag);
        chk("R5", {tag, " busy at done"}, int'(busy_o), 0);
        chk("R5", {tag, " hold at done"}, int'(hold_o), 0);
        @(negedge clk);
        chk("R5", {tag, " done width"}, int'(done_o), 0);
    endtask

    task automatic t_reset();
        chk("R1", "busy in reset", int'(busy_o), 0);
        chk("R1", "hold in reset", int'(hold_o), 0);
        chk("R1", "done in reset", int'(done_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "result after reset", int'(result_o), 0);
        chk("R1", "over after reset", int'(over_range_o), 0);
        chk("R1", "code after reset", int'(dac_code_o), 0);
        chk("R1", "busy idle", int'(busy_o), 0);
    endtask

    task automatic t_midscale();
        int lat;
        begin_conv(37);
        chk("R2", "busy after accept", int'(busy_o), 1);
        chk("R2", "hold after accept", int'(hold_o), 1);
        chk("R2", "code after accept", int'(dac_code_o), 0);
        @(negedge clk);
        chk("R3", "code settle cycle", int'(dac_code_o), 0);
        @(negedge clk);
        chk("R3", "code step 1", int'(dac_code_o), 1);
        @(negedge clk);
        chk("R3", "code step 2", int'(dac_code_o), 2);
        wait_done(3, lat);
        chk("R4", "mid latency", lat, 37 + 4);
        chk("R4", "mid result", int'(result_o), 37);
        chk("R4", "mid over", int'(over_range_o), 0);
        check_end("mid");
    endtask

    task automatic t_zero();
        int lat;
        begin_conv(0);
        wait_done(0, lat);
        chk("R4", "zero latency", lat, 4);
        chk("R4", "zero result", int'(result_o), 0);
        check_end("zero");
    endtask

    task automatic t_hold_value();
        int lat;
        begin_conv(37);
        wait_done(0, lat);
        @(negedge clk);
        begin_conv(200);
        repeat (10) @(negedge clk);
        chk("R6", "old result while busy", int'(result_o), 37);
        chk("R6", "old over while busy", int'(over_range_o), 0);
        wait_done(10, lat);
        chk("R4", "200 latency", lat, 204);
        chk("R4", "200 result", int'(result_o), 200);
        check_end("200");
    endtask

    task automatic t_ignore_start();
        int lat;
        begin_conv(60);
        repeat (20) @(negedge clk);
        start_i  = 1'b1;
        vin_live = 9'd5;
        @(negedge clk);
        start_i  = 1'b0;
        @(negedge clk);
        chk("R7", "code not cleared by start", int'(dac_code_o), 21);
        wait_done(22, lat);
        chk("R7", "latency unchanged", lat, 64);
        chk("R7", "result unchanged", int'(result_o), 60);
        check_end("ignore");
    endtask

    task automatic t_overrange();
        int lat;
        begin_conv(300);
        wait_done(0, lat);
        chk("R8", "over latency", lat, CMAX + 4);
        chk("R8", "over result", int'(result_o), CMAX);
        chk("R8", "over flag", int'(over_range_o), 1);
        chk("R10", "code capped", int'(dac_code_o), CMAX);
        check_end("over");
        begin_conv(10);
        repeat (5) @(negedge clk);
        chk("R6", "over flag kept while busy", int'(over_range_o), 1);
        wait_done(5, lat);
        chk("R6", "over flag cleared by next", int'(over_range_o), 0);
        chk("R4", "10 result", int'(result_o), 10);
        check_end("after over");
    endtask

    task automatic t_fullscale();
        int lat;
        begin_conv(CMAX);
        wait_done(0, lat);
        chk("R9", "full latency", lat, CMAX + 4);
        chk("R9", "full result", int'(result_o), CMAX);
        chk("R9", "full over flag", int'(over_range_o), 0);
        check_end("full");
    endtask

    task automatic t_back2back();
        int lat;
        begin_conv(50);
        wait_done(0, lat);
        chk("R4", "first latency", lat, 54);
        chk("R4", "first result", int'(result_o), expect_code(50));
        start_i  = 1'b1;
        vin_live = 9'd9;
        @(posedge clk);
        @(negedge clk);
        start_i  = 1'b0;
        chk("R11", "busy after chained start", int'(busy_o), 1);
        chk("R11", "code after chained start", int'(dac_code_o), 0);
        chk("R6", "first result kept", int'(result_o), 50);
        wait_done(0, lat);
        chk("R11", "chained latency", lat, 13);
        chk("R11", "chained result", int'(result_o), 9);
        check_end("chain");
    endtask

    initial begin
        rst_n    = 1'b0;
        start_i  = 1'b0;
        vin_live = '0;
        repeat (2) @(negedge clk);
        t_reset();
        t_midscale();
        t_zero();
        t_hold_value();
        t_ignore_start();
        t_overrange();
        t_fullscale();
        t_back2back();
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R4 watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule